// File: doc/BRIEF.md
# Windowed 64-bit Register Access Bridge

This block lets a host that only speaks 32-bit register writes and reads reach a bank of 64-bit registers inside an engine. The host sees a small window of 32-bit registers: two data words, a command word, a reset word, a status word and an interrupt-enable word. To write an inner register, the host fills the upper and the lower data words and then writes the command word with its top bit set. To read one, it writes the command with the top bit clear, waits for the busy flag to drop, and then reads the fetched value back through the two data words.

Only the command write starts an inner access. The bridge then runs one 64-bit transaction on the inner port. The inner port has a request phase with a valid/ready handshake and a separate response phase. Three error causes are kept as sticky bits: a response flagged as an error, an access that does not finish within a fixed number of cycles, and a command written while an access is still running. A summary flag sits in bit 31 of the status word. All error bits stay set until the host writes the reset word. An interrupt line reports the summary flag when the host has enabled it.

Top module: `win64_bridge`

## Requirements
- R1: After reset, both data words, the status word and the interrupt-enable word read as zero, and neither inner request valid nor irq is asserted.
- R2: A write to the upper data word (offset 0x00) or the lower data word (offset 0x04) changes only that word and starts no inner access.
- R3: A write to the command word (offset 0x08) with bit 31 set, while idle, starts one inner write. Its address is command bits 30:0 and its data is {upper word, lower word}. Inner request valid rises on the clock edge after the command write.
- R4: A command write with bit 31 clear starts one inner read. When the response completes without error, the upper and lower data words return response bits 63:32 and 31:0.
- R5: While inner request valid is high and ready is low, valid, write, address and data hold steady until ready is seen, unless the access is abandoned by timeout.
- R6: Status bit 0 reads 1 from the edge that accepts a command until the access ends. While it reads 0, inner request valid is low.
- R7: A response with the error flag set sets status bits 31 and 2 and leaves both data words unchanged.
- R8: An access that has not completed after TIMEOUT_CYCLES cycles (one more if ready arrived in the last request cycle) is abandoned. This sets status bits 31 and 1 and returns busy to 0.
- R9: A command write while busy is ignored (no second inner request) and sets status bits 31 and 3.
- R10: Error bits are sticky. Any write to the reset word (offset 0x18) clears status bits 31 and 3:1, whatever value is written.
- R11: The interrupt-enable word (offset 0x20) keeps bit 0 and reads it back. irq equals status bit 31 AND that bit.
- R12: Reads of offsets outside 0x00, 0x04, 0x08, 0x18, 0x1C and 0x20 return zero, and the command and reset words read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | HOST_AW | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr (combinational) |
| inr_req_valid | output | 1 | Inner request valid |
| inr_req_ready | input | 1 | Inner request accepted |
| inr_req_write | output | 1 | Inner request is a write |
| inr_req_addr | output | 31 | Inner register address |
| inr_req_wdata | output | 64 | Inner write data |
| inr_rsp_valid | input | 1 | Inner response valid |
| inr_rsp_data | input | 64 | Inner read data |
| inr_rsp_err | input | 1 | Inner response reports rejection |
| irq | output | 1 | Summary error interrupt, gated by enable |

## Verification
A wrong transfer state shows up at the ports within a few cycles. Either busy stays stuck, which a later poll catches because it must clear within the timeout window, or a request appears with no command behind it, which the engine model's request count exposes. Wrong data capture shows up at the next read of a data window: every random read is compared with a shadow copy of the engine's registers. Wrong error capture shows up in the status word read right after the offending access, and again after the reset-word write that must clear it.

// File: rtl/win64_pkg.sv
package win64_pkg;
  localparam int HOST_DW = 32;
  localparam int INR_AW  = 31;
  localparam int INR_DW  = 64;

  localparam int OFF_HI  = 'h00;
  localparam int OFF_LO  = 'h04;
  localparam int OFF_CMD = 'h08;
  localparam int OFF_RST = 'h18;
  localparam int OFF_STS = 'h1C;
  localparam int OFF_IEN = 'h20;

  localparam int STS_BUSY  = 0;
  localparam int STS_TMO   = 1;
  localparam int STS_REJ   = 2;
  localparam int STS_CLASH = 3;
  localparam int STS_ANY   = 31;

  typedef enum logic [1:0] {
    XF_IDLE = 2'd0,
    XF_REQ  = 2'd1,
    XF_RSP  = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/win64_rst_sync.sv
module win64_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/win64_regs.sv
module win64_regs
  import win64_pkg::*;
#(
  parameter int HOST_AW = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [HOST_DW-1:0] host_wdata,
  output logic [HOST_DW-1:0] host_rdata,
  input  logic               busy,
  input  logic               rd_load,
  input  logic [INR_DW-1:0]  rd_data,
  input  logic [HOST_DW-1:0] status_word,
  output logic [INR_DW-1:0]  data64,
  output logic               cmd_fire,
  output logic               cmd_clash,
  output logic               cmd_write,
  output logic [INR_AW-1:0]  cmd_addr,
  output logic               clr_pulse,
  output logic               irq_en
);
  logic [HOST_DW-1:0] hi_q, hi_d, lo_q, lo_d;
  logic               ien_q, ien_d;
  logic               hi_en, lo_en, ien_en;
  logic               hit_hi, hit_lo, hit_cmd, hit_rst, hit_ien;

  always_comb begin
    hit_hi  = host_wr && (host_addr == HOST_AW'(OFF_HI));
    hit_lo  = host_wr && (host_addr == HOST_AW'(OFF_LO));
    hit_cmd = host_wr && (host_addr == HOST_AW'(OFF_CMD));
    hit_rst = host_wr && (host_addr == HOST_AW'(OFF_RST));
    hit_ien = host_wr && (host_addr == HOST_AW'(OFF_IEN));

    cmd_fire  = hit_cmd && !busy;
    cmd_clash = hit_cmd && busy;
    cmd_write = host_wdata[HOST_DW-1];
    cmd_addr  = host_wdata[INR_AW-1:0];
    clr_pulse = hit_rst;

    // host writes take precedence over a completing inner read
    hi_d  = hit_hi ? host_wdata : rd_data[INR_DW-1:HOST_DW];
    lo_d  = hit_lo ? host_wdata : rd_data[HOST_DW-1:0];
    hi_en = hit_hi || rd_load;
    lo_en = hit_lo || rd_load;
    ien_d  = host_wdata[0];
    ien_en = hit_ien;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      ien_q <= 1'b0;
    end else begin
      if (hi_en)  hi_q  <= hi_d;
      if (lo_en)  lo_q  <= lo_d;
      if (ien_en) ien_q <= ien_d;
    end
  end

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      HOST_AW'(OFF_HI):  host_rdata = hi_q;
      HOST_AW'(OFF_LO):  host_rdata = lo_q;
      HOST_AW'(OFF_STS): host_rdata = status_word;
      HOST_AW'(OFF_IEN): host_rdata = {{(HOST_DW-1){1'b0}}, ien_q};
      default:           host_rdata = '0;
    endcase
  end

  assign data64 = {hi_q, lo_q};
  assign irq_en = ien_q;
endmodule

// File: rtl/win64_xfer.sv
module win64_xfer
  import win64_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_write,
  input  logic [INR_AW-1:0] start_addr,
  input  logic [INR_DW-1:0] start_wdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [INR_AW-1:0] req_addr,
  output logic [INR_DW-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [INR_DW-1:0] rsp_data,
  input  logic              rsp_err,
  output logic              busy,
  output logic              rd_load,
  output logic [INR_DW-1:0] rd_data,
  output logic              ev_timeout,
  output logic              ev_reject
);
  localparam int CW = $clog2(TIMEOUT_CYCLES + 2);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

  xfer_state_e       st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              wr_q;
  logic [INR_AW-1:0] addr_q;
  logic [INR_DW-1:0] wdata_q;
  logic              ld_en;

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    ld_en      = 1'b0;
    ev_timeout = 1'b0;
    ev_reject  = 1'b0;
    rd_load    = 1'b0;
    case (st_q)
      XF_IDLE: begin
        if (start) begin
          st_d  = XF_REQ;
          cnt_d = '0;
          ld_en = 1'b1;
        end
      end
      XF_REQ: begin
        if (req_ready) begin
          st_d  = XF_RSP;
          cnt_d = cnt_q + 1'b1;
        end else if (cnt_q >= LAST) begin
          st_d       = XF_IDLE;
          ev_timeout = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      XF_RSP: begin
        if (rsp_valid) begin
          st_d = XF_IDLE;
          if (rsp_err)      ev_reject = 1'b1;
          else if (!wr_q)   rd_load   = 1'b1;
        end else if (cnt_q >= LAST) begin
          st_d       = XF_IDLE;
          ev_timeout = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = XF_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= XF_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (ld_en) begin
        wr_q    <= start_write;
        addr_q  <= start_addr;
        wdata_q <= start_wdata;
      end
    end
  end

  assign req_valid = (st_q == XF_REQ);
  assign req_write = wr_q;
  assign req_addr  = addr_q;
  assign req_wdata = wdata_q;
  assign busy      = (st_q != XF_IDLE);
  assign rd_data   = rsp_data;
endmodule

// File: rtl/win64_err.sv
module win64_err
  import win64_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_timeout,
  input  logic               ev_reject,
  input  logic               ev_clash,
  input  logic               clear,
  input  logic               busy,
  output logic [HOST_DW-1:0] status_word
);
  logic [2:0] cause_q, cause_d;
  logic       cause_en;

  always_comb begin
    // a clear and a new event in the same cycle: the event is kept
    cause_d  = clear ? 3'b000 : cause_q;
    cause_d  = cause_d | {ev_clash, ev_reject, ev_timeout};
    cause_en = clear || ev_clash || ev_reject || ev_timeout;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cause_q <= '0;
    else if (cause_en) cause_q <= cause_d;
  end

  always_comb begin
    status_word            = '0;
    status_word[STS_BUSY]  = busy;
    status_word[STS_TMO]   = cause_q[0];
    status_word[STS_REJ]   = cause_q[1];
    status_word[STS_CLASH] = cause_q[2];
    status_word[STS_ANY]   = |cause_q;
  end
endmodule

// File: rtl/win64_bridge.sv
module win64_bridge
  import win64_pkg::*;
#(
  parameter int HOST_AW        = 6,
  parameter int TIMEOUT_CYCLES = 1024
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  output logic               inr_req_valid,
  input  logic               inr_req_ready,
  output logic               inr_req_write,
  output logic [30:0]        inr_req_addr,
  output logic [63:0]        inr_req_wdata,
  input  logic               inr_rsp_valid,
  input  logic [63:0]        inr_rsp_data,
  input  logic               inr_rsp_err,
  output logic               irq
);
  logic              rst_n_s;
  logic              busy;
  logic              rd_load;
  logic [INR_DW-1:0] rd_data;
  logic [31:0]       status_word;
  logic [INR_DW-1:0] data64;
  logic              cmd_fire, cmd_clash, cmd_write, clr_pulse, irq_en;
  logic [INR_AW-1:0] cmd_addr;
  logic              ev_timeout, ev_reject;

  win64_rst_sync #(.STAGES(2)) rst_i (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  win64_regs #(.HOST_AW(HOST_AW)) regs_i (
    .clk(clk), .rst_n(rst_n_s),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .busy(busy), .rd_load(rd_load), .rd_data(rd_data),
    .status_word(status_word), .data64(data64),
    .cmd_fire(cmd_fire), .cmd_clash(cmd_clash), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .clr_pulse(clr_pulse), .irq_en(irq_en)
  );

  win64_xfer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) xfer_i (
    .clk(clk), .rst_n(rst_n_s),
    .start(cmd_fire), .start_write(cmd_write), .start_addr(cmd_addr),
    .start_wdata(data64),
    .req_valid(inr_req_valid), .req_ready(inr_req_ready),
    .req_write(inr_req_write), .req_addr(inr_req_addr),
    .req_wdata(inr_req_wdata),
    .rsp_valid(inr_rsp_valid), .rsp_data(inr_rsp_data), .rsp_err(inr_rsp_err),
    .busy(busy), .rd_load(rd_load), .rd_data(rd_data),
    .ev_timeout(ev_timeout), .ev_reject(ev_reject)
  );

  win64_err err_i (
    .clk(clk), .rst_n(rst_n_s),
    .ev_timeout(ev_timeout), .ev_reject(ev_reject), .ev_clash(cmd_clash),
    .clear(clr_pulse), .busy(busy), .status_word(status_word)
  );

  assign irq = status_word[STS_ANY] && irq_en;
endmodule

// File: rtl/win64_bridge_chk.sv
module win64_bridge_chk #(
  parameter int HOST_AW        = 6,
  parameter int TIMEOUT_CYCLES = 1024
) (
  input logic               clk,
  input logic               rst_n_s,
  input logic               host_wr,
  input logic [HOST_AW-1:0] host_addr,
  input logic [31:0]        host_wdata,
  input logic               inr_req_valid,
  input logic               inr_req_ready,
  input logic               inr_req_write,
  input logic [30:0]        inr_req_addr,
  input logic [63:0]        inr_req_wdata,
  input logic [31:0]        status_word
);
  localparam int RW = $clog2(TIMEOUT_CYCLES + 3);
  logic [RW-1:0] run_q;
  logic          cmd_w, rst_w;

  assign cmd_w = host_wr && (host_addr == HOST_AW'('h08));
  assign rst_w = host_wr && (host_addr == HOST_AW'('h18));

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)            run_q <= '0;
    else if (!status_word[0]) run_q <= '0;
    else if (run_q != '1)     run_q <= run_q + 1'b1;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    inr_req_valid && !inr_req_ready |=>
      (inr_req_valid && $stable(inr_req_addr) && $stable(inr_req_wdata) &&
       $stable(inr_req_write)) || status_word[1]); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    !status_word[0] |-> !inr_req_valid); // R6

  AST_CMD_START: assert property (@(posedge clk) disable iff (!rst_n_s)
    cmd_w && !status_word[0] |=>
      inr_req_valid && inr_req_addr == $past(host_wdata[30:0]) &&
      inr_req_write == $past(host_wdata[31])); // R3

  AST_CLASH_FLAG: assert property (@(posedge clk) disable iff (!rst_n_s)
    cmd_w && status_word[0] |=> status_word[31] && status_word[3]); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n_s)
    status_word[31] && !rst_w |=> status_word[31]); // R10

  AST_TIMEOUT_BOUND: assert property (@(posedge clk) disable iff (!rst_n_s)
    int'(run_q) <= TIMEOUT_CYCLES + 1); // R8
endmodule

bind win64_bridge win64_bridge_chk #(
  .HOST_AW(HOST_AW), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
) chk_i (
  .clk(clk), .rst_n_s(rst_n_s), .host_wr(host_wr), .host_addr(host_addr),
  .host_wdata(host_wdata), .inr_req_valid(inr_req_valid),
  .inr_req_ready(inr_req_ready), .inr_req_write(inr_req_write),
  .inr_req_addr(inr_req_addr), .inr_req_wdata(inr_req_wdata),
  .status_word(status_word)
);

// File: tb/win64_bridge_tb_top.sv
module win64_bridge_tb_top;
  localparam int AW  = 6;
  localparam int TMO = 40;

  logic        clk;
  logic        rst_n;
  logic        host_wr;
  logic [AW-1:0] host_addr;
  logic [31:0] host_wdata, host_rdata;
  logic        inr_req_valid, inr_req_ready, inr_req_write;
  logic [30:0] inr_req_addr;
  logic [63:0] inr_req_wdata;
  logic        inr_rsp_valid, inr_rsp_err;
  logic [63:0] inr_rsp_data;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  int req_count = 0;
  logic        last_wr;
  logic [30:0] last_addr;
  logic [63:0] last_wdata;
  logic [63:0] eng_mem [16];
  logic [63:0] shadow  [16];
  bit          done = 0;

  win64_bridge #(.HOST_AW(AW), .TIMEOUT_CYCLES(TMO)) dut_i (.*);

  initial clk = 0;
  always #5 clk = ~clk;

  function automatic logic [63:0] init_val(int i);
    return {32'hA5A50000 + 32'(i), 32'h0F0F0000 ^ 32'(i * 7)};
  endfunction

  function automatic logic [31:0] base_addr(int idx);
    return 32'h0000_0070 + 32'(idx);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // inner engine model: addr bit 8 -> reject, addr bit 9 -> never accepts
  initial begin
    inr_req_ready = 0; inr_rsp_valid = 0; inr_rsp_err = 0; inr_rsp_data = '0;
    for (int i = 0; i < 16; i++) eng_mem[i] = init_val(i);
    forever begin
      @(negedge clk);
      if (inr_req_valid && !inr_req_addr[9]) begin
        automatic logic        w  = inr_req_write;
        automatic logic [30:0] a  = inr_req_addr;
        automatic logic [63:0] d  = inr_req_wdata;
        automatic int          d1 = int'($urandom_range(0, 4));
        automatic int          d2 = int'($urandom_range(0, 4));
        repeat (d1) @(negedge clk);
        inr_req_ready = 1;
        @(negedge clk);
        inr_req_ready = 0;
        req_count++;
        last_wr = w; last_addr = a; last_wdata = d;
        repeat (d2) @(negedge clk);
        inr_rsp_valid = 1;
        inr_rsp_err   = a[8];
        inr_rsp_data  = a[8] ? 64'hDEAD_DEAD_DEAD_DEAD : eng_mem[a[3:0]];
        if (w && !a[8]) eng_mem[a[3:0]] = d;
        @(negedge clk);
        inr_rsp_valid = 0;
        inr_rsp_err   = 0;
      end
    end
  end

  task automatic hwrite(input int off, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1; host_addr = AW'(off); host_wdata = d;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic hread(input int off, output logic [31:0] d);
    host_addr = AW'(off);
    #1 d = host_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 200; i++) begin
      hread('h1C, s);
      if (!s[0]) return;
      @(negedge clk);
    end
  endtask

  task automatic do_write(input int idx, input logic [63:0] v);
    hwrite('h00, v[63:32]);
    hwrite('h04, v[31:0]);
    hwrite('h08, 32'h8000_0000 | base_addr(idx));
    wait_idle();
    shadow[idx] = v;
  endtask

  task automatic do_read(input int idx, output logic [63:0] v);
    logic [31:0] h, l;
    hwrite('h08, base_addr(idx));
    wait_idle();
    hread('h00, h);
    hread('h04, l);
    v = {h, l};
  endtask

  initial begin
    logic [31:0] r, r2;
    logic [63:0] v;
    int          rc0;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 16; i++) shadow[i] = init_val(i);
    host_wr = 0; host_addr = '0; host_wdata = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    hread('h00, r); chk(r == 0, "R1 hi", 64'(r), 0);
    hread('h04, r); chk(r == 0, "R1 lo", 64'(r), 0);
    hread('h1C, r); chk(r == 0, "R1 status", 64'(r), 0);
    hread('h20, r); chk(r == 0, "R1 ien", 64'(r), 0);
    chk(!inr_req_valid && !irq, "R1 valid/irq", {inr_req_valid, irq}, 0);

    // R2 data windows independent, no inner access
    rc0 = req_count;
    hwrite('h00, 32'h1111_2222);
    chk(!inr_req_valid, "R2 no req after hi", 64'(inr_req_valid), 0);
    hread('h04, r); chk(r == 0, "R2 lo untouched", 64'(r), 0);
    hwrite('h04, 32'h3333_4444);
    hread('h00, r); chk(r == 32'h1111_2222, "R2 hi kept", 64'(r), 64'h11112222);
    repeat (6) @(negedge clk);
    chk(req_count == rc0 && !inr_req_valid, "R2 no request", 64'(req_count), 64'(rc0));

    // R3 / R6 directed write
    hwrite('h08, 32'h8000_0000 | base_addr(5));
    hread('h1C, r); chk(r[0], "R6 busy after cmd", 64'(r), 1);
    wait_idle();
    shadow[5] = 64'h1111_2222_3333_4444;
    chk(req_count == rc0 + 1, "R3 one request", 64'(req_count), 64'(rc0 + 1));
    chk(last_wr && last_addr == base_addr(5) && last_wdata == 64'h1111_2222_3333_4444,
        "R3 inner write", last_wdata, 64'h1111_2222_3333_4444);
    hread('h1C, r); chk(r == 0, "R6 idle status", 64'(r), 0);

    // R4 directed reads incl. written one
    do_read(5, v); chk(v == shadow[5], "R4 read back", v, shadow[5]);
    do_read(0, v); chk(v == shadow[0], "R4 read idx0", v, shadow[0]);
    chk(!last_wr && last_addr == base_addr(0), "R4 read addr", 64'(last_addr), 64'(base_addr(0)));

    // random mix
    for (int k = 0; k < 40; k++) begin
      automatic int idx = int'($urandom_range(0, 15));
      if ($urandom_range(0, 1) == 1) begin
        do_write(idx, {$urandom(), $urandom()});
      end else begin
        do_read(idx, v);
        chk(v == shadow[idx], "R4 random read", v, shadow[idx]);
      end
    end

    // R11 enable, R7 reject
    hwrite('h20, 32'hFFFF_FFFF);
    hread('h20, r); chk(r == 1, "R11 ien readback", 64'(r), 1);
    chk(!irq, "R11 irq low no error", 64'(irq), 0);
    hwrite('h00, 32'hCAFE_0001);
    hwrite('h04, 32'hCAFE_0002);
    hwrite('h08, 32'h0000_0100 | base_addr(3));
    wait_idle();
    hread('h1C, r); chk(r == 32'h8000_0004, "R7 reject status", 64'(r), 64'h80000004);
    hread('h00, r); hread('h04, r2);
    chk({r, r2} == 64'hCAFE_0001_CAFE_0002, "R7 windows kept", {r, r2}, 64'hCAFE_0001_CAFE_0002);
    chk(irq, "R11 irq on error", 64'(irq), 1);
    hwrite('h20, 0);
    chk(!irq, "R11 irq masked", 64'(irq), 0);

    // R10 sticky then clear
    hwrite('h04, 32'h5);
    hread('h1C, r); chk(r[31], "R10 sticky", 64'(r), 64'h80000004);
    hwrite('h18, 32'h0);
    hread('h1C, r); chk(r == 0, "R10 cleared", 64'(r), 0);

    // R9 collision during hung access, R8 timeout
    rc0 = req_count;
    hwrite('h08, 32'h0000_0200 | base_addr(1));
    hwrite('h08, base_addr(2));
    hread('h1C, r); chk(r[31] && r[3] && r[0], "R9 clash flag", 64'(r), 64'h80000009);
    repeat (TMO + 5) @(negedge clk);
    hread('h1C, r); chk(r == 32'h8000_000A, "R8 timeout status", 64'(r), 64'h8000000A);
    chk(req_count == rc0 && !inr_req_valid, "R9 no second request", 64'(req_count), 64'(rc0));
    hwrite('h18, 32'hFFFF_FFFF);
    hread('h1C, r); chk(r == 0, "R10 clear any value", 64'(r), 0);
    do_read(2, v); chk(v == shadow[2], "R8 recovers", v, shadow[2]);

    // R12 unmapped / write-only offsets
    hread('h0C, r); chk(r == 0, "R12 off 0C", 64'(r), 0);
    hread('h10, r); chk(r == 0, "R12 off 10", 64'(r), 0);
    hread('h24, r); chk(r == 0, "R12 off 24", 64'(r), 0);
    hread('h08, r); chk(r == 0, "R12 cmd reads zero", 64'(r), 0);
    hread('h18, r); chk(r == 0, "R12 rst reads zero", 64'(r), 0);

    done = 1;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    #2;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule